// File: doc/BRIEF.md
# Instruction Fetch Stage with Hazard Stall

This block holds the program counter and the instruction register that sits between the fetch and decode stages of a five-stage pipeline with word addressing. On every clock edge it either advances the program counter by one word or redirects it to a branch target. The branch target is an absolute address taken from the instruction currently held for decode. In the same cycle it captures the newly fetched instruction word.

The block also decides when fetch must freeze. A conditional branch in decode has to wait while the instruction one stage ahead is an ALU operation that writes a register, because the flag it tests is not ready yet. Any other instruction waits on the external load-use hazard flag, except a store, which is never held here. When fetch freezes, the program counter and the held instruction keep their values together. A single write-enable output tells instruction memory and the next stage whether fetch advanced.

Top module: `fetch_stage`

## Requirements
- R1: With no stall and `branchTaken` low, the PC one cycle later equals the previous PC plus 1, wrapping modulo 2^PC_W.
- R2: With no stall and `branchTaken` high, the next PC is bits [25:0] of the held instruction `ifidInstr`, sign-extended from bit 25 to PC_W bits.
- R3: `fetchAdvance` is high exactly when fetch is not stalled. When it is high, the PC updates and `ifidInstr` takes `fetchInstr` on the same edge, so both registers always move together.
- R4: When `idOpcode` is 10 or 11 (conditional branch), fetch stalls exactly when `exMemRegWrite` is 1 and `exMemIsLoad` is 0. For these opcodes `loadUseHazard` has no effect.
- R5: For any opcode other than 9, 10 and 11, fetch stalls exactly when `loadUseHazard` is 1.
- R6: When `idOpcode` is 9 (store), fetch never stalls, whatever `loadUseHazard` and the EXE/MEM flags are.
- R7: While stalled, the PC and `ifidInstr` keep their previous values, even when `branchTaken` is high.
- R8: A synchronous active-high `rst` sets the PC to 0 and `ifidInstr` to the no-op word NOP_WORD (default 0) on the next edge. Reset takes precedence over every other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fetchInstr | input | INSTR_W | Word read from instruction memory at `pcOut` |
| branchTaken | input | 1 | Decode resolved a taken branch |
| idOpcode | input | OPC_W | Opcode of the instruction in decode |
| loadUseHazard | input | 1 | A load ahead blocks the instruction in decode |
| exMemRegWrite | input | 1 | The EXE/MEM instruction writes a register |
| exMemIsLoad | input | 1 | The EXE/MEM instruction is a load |
| pcOut | output | PC_W | Current program counter (word address) |
| ifidInstr | output | INSTR_W | Instruction held for decode |
| fetchAdvance | output | 1 | PC and IF/ID write enable for this cycle |

## Verification
The bench first runs plain sequential fetch with varied instruction words, which shows that PC and IF/ID advance together. It then drives each stall source with each opcode class: a hazard on an ALU opcode, the same hazard on a store, and a branch opcode whose EXE/MEM neighbour is an ALU writer, a load, or a non-writer. These cases separate the three stall rules from one another. Taken branches use one negative and one positive 26-bit target, which exposes sign-extension faults. A taken branch while stalled checks that the freeze overrides redirection, and a reset mid-run checks that reset wins over everything else.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

  // Strobes from stall control to the fetch datapath
  typedef struct packed {
    logic pcWrite;
    logic irWrite;
    logic takeBranch;
  } fetchStrobe_t;

endpackage

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
  import fetch_pkg::*;
#(
  parameter int OPC_W     = 6,
  parameter int STORE_OPC = 9,
  parameter int CBR_A_OPC = 10,
  parameter int CBR_B_OPC = 11
) (
  input  logic [OPC_W-1:0] idOpcode,
  input  logic             branchTaken,
  input  logic             loadUseHazard,
  input  logic             exMemRegWrite,
  input  logic             exMemIsLoad,
  output fetchStrobe_t     strobe
);

  localparam logic [OPC_W-1:0] StoreCode = OPC_W'(STORE_OPC);
  localparam logic [OPC_W-1:0] CbrACode  = OPC_W'(CBR_A_OPC);
  localparam logic [OPC_W-1:0] CbrBCode  = OPC_W'(CBR_B_OPC);

  logic isCondBranch;
  logic isStore;
  logic flagWait;
  logic loadWait;
  logic stall;

  always_comb begin
    isCondBranch = (idOpcode == CbrACode) || (idOpcode == CbrBCode);
    isStore      = (idOpcode == StoreCode);
    // branch waits for an ALU result that will set the flag
    flagWait     = exMemRegWrite && !exMemIsLoad;
    // store data is forwarded later, so a store passes the hazard
    loadWait     = loadUseHazard && !isStore;
    stall        = isCondBranch ? flagWait : loadWait;

    strobe.pcWrite    = !stall;
    strobe.irWrite    = !stall;
    strobe.takeBranch = branchTaken;
  end

endmodule

// File: rtl/fetch_datapath.sv
module fetch_datapath
  import fetch_pkg::*;
#(
  parameter int          PC_W     = 32,
  parameter int          INSTR_W  = 32,
  parameter int          TGT_W    = 26,
  parameter logic [31:0] NOP_WORD = 32'h0
) (
  input  logic               clk,
  input  logic               rst,
  input  fetchStrobe_t       strobe,
  input  logic [INSTR_W-1:0] fetchInstr,
  output logic [PC_W-1:0]    pcQ,
  output logic [INSTR_W-1:0] irQ
);

  localparam logic [INSTR_W-1:0] NopInstr = INSTR_W'(NOP_WORD);
  localparam logic [PC_W-1:0]    PcOne    = PC_W'(1);

  logic [TGT_W-1:0] rawTarget;
  logic [PC_W-1:0]  branchTarget;
  logic [PC_W-1:0]  nextPc;

  assign rawTarget = irQ[TGT_W-1:0];

  generate
    if (PC_W > TGT_W) begin : g_sext
      assign branchTarget = {{(PC_W-TGT_W){rawTarget[TGT_W-1]}}, rawTarget};
    end else begin : g_trunc
      assign branchTarget = rawTarget[PC_W-1:0];
    end
  endgenerate

  always_comb begin
    nextPc = strobe.takeBranch ? branchTarget : (pcQ + PcOne);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcQ <= '0;
    end else if (strobe.pcWrite) begin
      pcQ <= nextPc;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irQ <= NopInstr;
    end else if (strobe.irWrite) begin
      irQ <= fetchInstr;
    end
  end

  // R1
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.pcWrite && !strobe.takeBranch) |=> (pcQ == $past(pcQ) + PcOne));

  // R3
  ir_load_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.irWrite |=> (irQ == $past(fetchInstr)));

  // R7
  ir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe.irWrite |=> $stable(irQ));

endmodule

// File: rtl/fetch_stage.sv
module fetch_stage
  import fetch_pkg::*;
#(
  parameter int          PC_W      = 32,
  parameter int          INSTR_W   = 32,
  parameter int          OPC_W     = 6,
  parameter int          TGT_W     = 26,
  parameter int          STORE_OPC = 9,
  parameter int          CBR_A_OPC = 10,
  parameter int          CBR_B_OPC = 11,
  parameter logic [31:0] NOP_WORD  = 32'h0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] fetchInstr,
  input  logic               branchTaken,
  input  logic [OPC_W-1:0]   idOpcode,
  input  logic               loadUseHazard,
  input  logic               exMemRegWrite,
  input  logic               exMemIsLoad,
  output logic [PC_W-1:0]    pcOut,
  output logic [INSTR_W-1:0] ifidInstr,
  output logic               fetchAdvance
);

  fetchStrobe_t strobe;

  fetch_ctrl #(
    .OPC_W    (OPC_W),
    .STORE_OPC(STORE_OPC),
    .CBR_A_OPC(CBR_A_OPC),
    .CBR_B_OPC(CBR_B_OPC)
  ) u_ctrl (
    .idOpcode     (idOpcode),
    .branchTaken  (branchTaken),
    .loadUseHazard(loadUseHazard),
    .exMemRegWrite(exMemRegWrite),
    .exMemIsLoad  (exMemIsLoad),
    .strobe       (strobe)
  );

  fetch_datapath #(
    .PC_W    (PC_W),
    .INSTR_W (INSTR_W),
    .TGT_W   (TGT_W),
    .NOP_WORD(NOP_WORD)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .fetchInstr(fetchInstr),
    .pcQ       (pcOut),
    .irQ       (ifidInstr)
  );

  assign fetchAdvance = strobe.pcWrite;

  localparam logic [OPC_W-1:0] StoreCode = OPC_W'(STORE_OPC);
  localparam logic [OPC_W-1:0] CbrACode  = OPC_W'(CBR_A_OPC);
  localparam logic [OPC_W-1:0] CbrBCode  = OPC_W'(CBR_B_OPC);

  // R4
  cbr_flag_stall_chk: assert property (@(posedge clk) disable iff (rst)
    ((idOpcode == CbrACode || idOpcode == CbrBCode) && exMemRegWrite && !exMemIsLoad)
      |=> ($stable(pcOut) && $stable(ifidInstr)));

  // R5
  load_use_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (idOpcode != CbrACode && idOpcode != CbrBCode && idOpcode != StoreCode && loadUseHazard)
      |=> $stable(pcOut));

  // R6
  store_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (idOpcode == StoreCode) |-> fetchAdvance);

  // R8
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (pcOut == '0 && ifidInstr == INSTR_W'(NOP_WORD)));

endmodule

// File: tb/fetch_stage_test.sv
module fetch_stage_test;

  localparam int ClkPeriod = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] fetchInstr = '0;
  logic        branchTaken = 1'b0;
  logic [5:0]  idOpcode = '0;
  logic        loadUseHazard = 1'b0;
  logic        exMemRegWrite = 1'b0;
  logic        exMemIsLoad = 1'b0;
  logic [31:0] pcOut;
  logic [31:0] ifidInstr;
  logic        fetchAdvance;

  fetch_stage uut (
    .clk          (clk),
    .rst          (rst),
    .fetchInstr   (fetchInstr),
    .branchTaken  (branchTaken),
    .idOpcode     (idOpcode),
    .loadUseHazard(loadUseHazard),
    .exMemRegWrite(exMemRegWrite),
    .exMemIsLoad  (exMemIsLoad),
    .pcOut        (pcOut),
    .ifidInstr    (ifidInstr),
    .fetchAdvance (fetchAdvance)
  );

  always #(ClkPeriod/2) clk = ~clk;

  typedef struct packed {
    logic [31:0] pc;
    logic [31:0] ir;
  } expItem_t;

  expItem_t expQ[$];
  string    tagQ[$];
  int       checkCount = 0;
  int       failCount  = 0;
  logic [31:0] mPc = '0;
  logic [31:0] mIr = '0;
  bit       done = 0;

  // Apply one cycle of inputs, check the enable, predict the next state
  task automatic step(input bit r, input logic [31:0] instr, input bit br,
                      input logic [5:0] opc, input bit haz, input bit wreg,
                      input bit ld, input string tag);
    bit stall;
    bit expWe;
    @(negedge clk);
    rst = r; fetchInstr = instr; branchTaken = br; idOpcode = opc;
    loadUseHazard = haz; exMemRegWrite = wreg; exMemIsLoad = ld;
    if (opc == 6'd10 || opc == 6'd11) stall = wreg && !ld;
    else stall = haz && (opc != 6'd9);
    expWe = !stall;
    #1;
    if (!r) begin
      checkCount++;
      if (fetchAdvance !== expWe) begin
        failCount++;
        $display("FAIL %s R3 enable: actual=%0b expected=%0b", tag, fetchAdvance, expWe);
      end
    end
    if (r) begin
      mPc = '0; mIr = '0;
    end else if (expWe) begin
      mPc = br ? {{6{mIr[25]}}, mIr[25:0]} : mPc + 32'd1;
      mIr = instr;
    end
    expQ.push_back('{pc: mPc, ir: mIr});
    tagQ.push_back(tag);
  endtask

  // Monitor: compare after each edge
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      expItem_t e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checkCount++;
      if (pcOut !== e.pc) begin
        failCount++;
        $display("FAIL %s pc: actual=%h expected=%h", t, pcOut, e.pc);
      end
      checkCount++;
      if (ifidInstr !== e.ir) begin
        failCount++;
        $display("FAIL %s ifid: actual=%h expected=%h", t, ifidInstr, e.ir);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failCount++;
      $display("FAIL watchdog all requirements: actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    // R8 reset state
    step(1, 32'hDEAD_BEEF, 1, 6'd0, 0, 0, 0, "R8 reset");
    // R1 R3 plain sequential fetch
    step(0, 32'h1111_0001, 0, 6'd0, 0, 0, 0, "R1 seq a");
    step(0, 32'h2222_0002, 0, 6'd3, 0, 0, 0, "R1 seq b");
    step(0, 32'h3333_0003, 0, 6'd0, 0, 1, 1, "R3 seq c");
    // R5 load-use stall on ALU opcode, R7 hold
    step(0, 32'h4444_0004, 0, 6'd1, 1, 0, 0, "R5 hazard alu");
    step(0, 32'h4444_0005, 0, 6'd12, 1, 1, 0, "R5 hazard other");
    // R6 store passes hazard
    step(0, 32'h5555_0006, 0, 6'd9, 1, 1, 0, "R6 store hazard");
    // R4 branch opcodes
    step(0, 32'h6666_0007, 0, 6'd10, 0, 1, 0, "R4 cbr10 alu writer");
    step(0, 32'h6666_0008, 0, 6'd11, 0, 1, 0, "R4 cbr11 alu writer");
    step(0, 32'h6666_0009, 0, 6'd10, 0, 1, 1, "R4 cbr10 load ahead");
    step(0, 32'h6666_000A, 0, 6'd11, 1, 0, 0, "R4 cbr11 hazard ignored");
    // R2 negative target: hold word with low 26 bits 3FFFFF0
    step(0, 32'hFBFF_FFF0, 0, 6'd0, 0, 0, 0, "R2 load neg word");
    step(0, 32'h7777_000B, 1, 6'd10, 0, 0, 0, "R2 neg target");
    // R2 positive target 0x123
    step(0, 32'h0000_0123, 0, 6'd0, 0, 0, 0, "R2 load pos word");
    step(0, 32'h7777_000C, 1, 6'd12, 0, 0, 0, "R2 pos target");
    // R7 stalled with branch taken holds
    step(0, 32'h8888_000D, 1, 6'd11, 0, 1, 0, "R7 stall over branch");
    step(0, 32'h8888_000E, 1, 6'd2, 1, 0, 0, "R7 hazard over branch");
    step(0, 32'h8888_000F, 0, 6'd2, 0, 0, 0, "R1 resume");
    // R8 reset mid-run wins over stall and branch
    step(1, 32'h9999_0010, 1, 6'd10, 1, 1, 0, "R8 reset mid");
    step(0, 32'h9999_0011, 0, 6'd0, 0, 0, 0, "R1 after reset");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule